// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block sits between a two-wire SMBus and a bank of 8-bit configuration registers owned elsewhere in the chip. It recognises start and repeated-start conditions, checks the device address, decodes the command byte into an access mode and a starting register, and acknowledges every byte it accepts. Writes reach the register bank as a one-cycle strobe with an address and a data byte. Reads take their data combinationally from the bank through the same address output.

Bit 7 of the command chooses between two modes. When it is set, bits 6:0 give a single register to write or read. When it is clear, the access is a block that always starts at register 0 and walks upward. A block write carries a byte count before its data. A block read returns a count of implemented registers before the data bytes. The master may end any transfer after a whole byte. The slave only ever pulls SDA low, through an open-drain enable, and each stop condition is marked on a one-cycle end-of-transaction output.

Top module: `smbc_slave`

## Requirements
- R1: The slave acknowledges only the address byte D2h (7-bit address 1101001 with R/W = 0) or D3h (read). For any other address it leaves SDA released through the acknowledge bit and makes no register write. While idle it never drives SDA.
- R2: A command byte with bit 7 = 1 selects byte mode, with bits 6:0 as the register offset. The first data byte after it is written to that offset with a single one-cycle `reg_we` pulse.
- R3: A command byte with bit 7 = 0 selects block mode. The byte that follows it is a count and is acknowledged. Each later data byte is acknowledged and written to offsets 0, 1, 2 and upward in order.
- R4: A byte read (command with bit 7 = 1, repeated start, D3h) returns the register at the command's offset, MSB first. The master then ends with a not-acknowledge.
- R5: A block read (command 00h, repeated start, D3h) first returns the byte count NREGS. It then returns registers 0, 1, 2 and upward for as long as the master acknowledges. After a not-acknowledge the slave releases SDA.
- R6: A data byte aimed at an offset of NREGS or more is not acknowledged and is not written. So is a second data byte in byte mode.
- R7: A stop condition returns the slave to idle. If the slave had been addressed, a stop gives exactly one one-cycle `xfer_end` pulse. After reset `sda_oe`, `reg_we` and `xfer_end` are low.
- R8: The slave changes `sda_oe` only while SCL is low. The one exception is release on a start or stop, so read data stays stable across every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| reg_addr | output | AW | Register offset for the write strobe or the read data |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |
| xfer_end | output | 1 | One-cycle pulse on a stop ending an addressed transfer |

## Verification
The assertions assume that SCL and SDA are slow against `clk`: each level must hold for many more cycles than the synchroniser depth. They also assume that the master changes SDA only while SCL is low, except when it makes a start or stop. The bench drives both lines from tasks with a quarter-bit time of ten clocks. It moves SDA only in the low phase of SCL, and it models the wired-AND line from the master's drive and `sda_oe`. Random offsets are kept below NREGS, except in one directed case that probes the out-of-range rule.

// File: rtl/smbc_pkg.sv
package smbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_ACKH, ST_TX, ST_MACK, ST_TXLD, ST_HOLD
  } smbc_state_e;

  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} smbc_phase_e;

  // address byte carries our 7-bit address in bits 7:1
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // bit 7 set: single-register access
  function automatic logic cmd_is_byte(input logic [7:0] c);
    return c[7];
  endfunction

  // block accesses always start from offset zero
  function automatic logic [6:0] cmd_first_offset(input logic [7:0] c);
    return c[7] ? c[6:0] : 7'd0;
  endfunction

endpackage

// File: rtl/smbc_line_mon.sv
module smbc_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_s    = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbc_shift8.sv
module smbc_shift8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic         sh_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= ld_val;
    else if (sh) q <= {q[W-2:0], sh_in};
  end
endmodule

// File: rtl/smbc_slave.sv
module smbc_slave
  import smbc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREGS       = 18,
  parameter int         AW          = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata,
  output logic          xfer_end
);
  localparam logic [AW-1:0] LAST_OFF = AW'(NREGS);
  localparam logic [7:0]    CNT_BYTE = 8'(NREGS);

  // named bus events, shared with the assertions
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, bus_evt;

  smbc_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );
  assign bus_evt = start_ev | stop_ev;

  smbc_state_e st;
  smbc_phase_e ph;
  logic [3:0]    bitcnt;
  logic          blk, go_tx, cnt_sent, wrote_one;
  logic [AW-1:0] ptr, wr_addr_q;
  logic          oe_q, we_q, end_q;
  logic [7:0]    wdata_q, sh_q, rx_byte, tx_next;
  logic          byte_done, sh_en, ld_en, data_ok;

  assign rx_byte   = {sh_q[6:0], sda_s};
  assign byte_done = (st == ST_RX) && scl_rise && (bitcnt == 4'd7);
  assign tx_next   = (blk && !cnt_sent) ? CNT_BYTE : reg_rdata;
  assign ld_en     = scl_fall && !bus_evt &&
                     (((st == ST_ACKH) && go_tx) || (st == ST_TXLD));
  assign sh_en     = !bus_evt && (((st == ST_RX) && scl_rise) ||
                     ((st == ST_TX) && scl_fall && (bitcnt != 4'd8)));
  assign data_ok   = (ptr < LAST_OFF) && (blk || !wrote_one);

  smbc_shift8 #(.W(8)) u_sh (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(tx_next),
    .sh(sh_en), .sh_in((st == ST_RX) ? sda_s : 1'b0), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  ph <= PH_ADDR;  bitcnt <= '0;
      blk <= 1'b0;  go_tx <= 1'b0;  cnt_sent <= 1'b0;  wrote_one <= 1'b0;
      ptr <= '0;  wr_addr_q <= '0;  wdata_q <= '0;
      oe_q <= 1'b0;  we_q <= 1'b0;  end_q <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      end_q <= 1'b0;
      if (stop_ev) begin
        end_q <= (st != ST_IDLE);
        st    <= ST_IDLE;
        oe_q  <= 1'b0;
      end else if (start_ev) begin
        st <= ST_RX;  ph <= PH_ADDR;  bitcnt <= '0;  oe_q <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              st <= ST_ACK;
              unique case (ph)
                PH_ADDR: if (addr_hit(rx_byte, DEV_ADDR)) begin
                  go_tx <= rx_byte[0];
                  ph    <= PH_CMD;
                end else st <= ST_IDLE;
                PH_CMD: begin
                  blk       <= !cmd_is_byte(rx_byte);
                  ptr       <= AW'(cmd_first_offset(rx_byte));
                  ph        <= cmd_is_byte(rx_byte) ? PH_DATA : PH_CNT;
                  cnt_sent  <= 1'b0;
                  wrote_one <= 1'b0;
                end
                PH_CNT: ph <= PH_DATA;
                PH_DATA: if (data_ok) begin
                  we_q      <= 1'b1;
                  wr_addr_q <= ptr;
                  wdata_q   <= rx_byte;
                  wrote_one <= 1'b1;
                  if (blk) ptr <= ptr + AW'(1);
                end else st <= ST_HOLD;
                default: st <= ST_HOLD;
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            oe_q <= 1'b1;
            st   <= ST_ACKH;
          end
          ST_ACKH: if (scl_fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              oe_q <= ~tx_next[7];
              st   <= ST_TX;
              if (blk && !cnt_sent) cnt_sent <= 1'b1;
              else if (blk)         ptr <= ptr + AW'(1);
            end else begin
              oe_q <= 1'b0;
              st   <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && bitcnt != 4'd8) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe_q <= 1'b0;
                st   <= ST_MACK;
              end else oe_q <= ~sh_q[6];
            end
          end
          ST_MACK: if (scl_rise) st <= sda_s ? ST_HOLD : ST_TXLD;
          ST_TXLD: if (scl_fall) begin
            bitcnt <= '0;
            oe_q   <= ~tx_next[7];
            st     <= ST_TX;
            if (blk && !cnt_sent) cnt_sent <= 1'b1;
            else if (blk)         ptr <= ptr + AW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign xfer_end  = end_q;
  assign reg_addr  = we_q ? wr_addr_q : ptr;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R6
  we_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr < LAST_OFF));
  // R7
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);
  // R8
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(bus_evt)) |-> !$past(scl_s));
endmodule

// File: tb/smbc_slave_tb.sv
`timescale 1ns/1ps
module smbc_slave_tb;
  localparam int NREGS = 18;
  localparam int Q     = 50;   // quarter bit time in ns (10 clocks)

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, xfer_end;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  smbc_slave #(.NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .xfer_end(xfer_end)
  );

  // bench-side register bank fed by the write port
  logic [7:0] bank [0:127];
  logic [7:0] exp_reg [0:127];
  int wr_cnt = 0, xe_cnt = 0, tests = 0, fails = 0, hi_glitch = 0;
  assign reg_rdata = (int'(reg_addr) < NREGS) ? bank[reg_addr] : 8'h00;
  always @(posedge clk) begin
    if (reg_we) begin bank[reg_addr] <= reg_wdata; wr_cnt++; end
    if (xfer_end) xe_cnt++;
  end

  task automatic chk(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic rd);
    return {7'h69, rd};
  endfunction
  function automatic logic [7:0] byte_cmd(input int off);
    return 8'h80 | 8'(off);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; ack = (sda_line == 1'b0); #Q; scl = 1'b0; #Q;
  endtask
  task automatic recv(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_line;
      #(Q-3); if (sda_line != b[i]) hi_glitch++; #3; scl = 1'b0; #Q;
    end
    sda_m = nack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, output logic a_ack, output logic d_ack);
    logic c_ack;
    bus_start(); send(addr_byte(1'b0), a_ack); send(byte_cmd(off), c_ack);
    send(d, d_ack); bus_stop();
  endtask
  task automatic byte_read(input int off, output logic [7:0] d);
    logic a;
    bus_start(); send(addr_byte(1'b0), a); send(byte_cmd(off), a);
    bus_start(); send(addr_byte(1'b1), a); recv(d, 1'b1); bus_stop();
  endtask

  logic a1, a2, a3;
  logic [7:0] rb;
  int wc0, xe0;

  initial begin
    #100; rst_n = 1'b1; #50;
    // R7 reset state
    chk("R7 reset sda_oe", sda_oe, 0);
    chk("R7 reset reg_we", reg_we, 0);
    chk("R7 reset xfer_end", xfer_end, 0);

    // R1 R2 directed byte write, then R4 byte read
    xe0 = xe_cnt;
    byte_write(5, 8'hA5, a1, a2); exp_reg[5] = 8'hA5;
    chk("R1 address ack", a1, 1);
    chk("R2 data ack", a2, 1);
    byte_read(5, rb);
    chk("R4 byte read offset 5", rb, 8'hA5);
    #(4*Q);
    chk("R7 xfer_end per stop", xe_cnt - xe0, 2);

    // R6 second data byte in byte mode
    wc0 = wr_cnt;
    bus_start(); send(addr_byte(1'b0), a1); send(byte_cmd(3), a1);
    send(8'h3C, a2); send(8'hC3, a3); bus_stop(); exp_reg[3] = 8'h3C;
    chk("R6 first byte ack", a2, 1);
    chk("R6 extra byte nack", a3, 0);
    chk("R6 one write only", wr_cnt - wc0, 1);
    byte_read(3, rb);
    chk("R6 kept first byte", rb, 8'h3C);

    // R6 out-of-range offset
    wc0 = wr_cnt;
    byte_write(NREGS + 2, 8'h77, a1, a2);
    chk("R6 out-of-range nack", a2, 0);
    chk("R6 out-of-range no write", wr_cnt - wc0, 0);

    // R1 wrong address
    wc0 = wr_cnt; xe0 = xe_cnt;
    bus_start(); send(8'hA0, a1); send(8'h81, a2); bus_stop(); #(4*Q);
    chk("R1 foreign address nack", a1, 0);
    chk("R1 foreign no write", wr_cnt - wc0, 0);
    chk("R7 no end pulse when unaddressed", xe_cnt - xe0, 0);

    // R3 block write of 7 bytes
    wc0 = wr_cnt;
    bus_start(); send(addr_byte(1'b0), a1); send(8'h00, a1);
    send(8'd7, a2); chk("R3 count ack", a2, 1);
    for (int i = 0; i < 7; i++) begin
      send(8'h10 + 8'(i * 3), a3); exp_reg[i] = 8'h10 + 8'(i * 3);
      chk("R3 block data ack", a3, 1);
    end
    bus_stop();
    chk("R3 block write count", wr_cnt - wc0, 7);
    byte_read(6, rb);
    chk("R3 last block byte at offset 6", rb, exp_reg[6]);

    // R2 R4 random byte traffic, fixed seed
    void'($urandom(32'h5EED));
    for (int k = 0; k < 24; k++) begin
      int off = int'($urandom % NREGS);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 2) begin
        byte_write(off, d, a1, a2); exp_reg[off] = d;
        chk("R2 random write ack", a2, 1);
      end else begin
        byte_read(off, rb);
        chk("R4 random read", rb, exp_reg[off]);
      end
    end

    // R5 block read of whole bank
    bus_start(); send(addr_byte(1'b0), a1); send(8'h00, a1);
    bus_start(); send(addr_byte(1'b1), a1);
    recv(rb, 1'b0); chk("R5 count byte", rb, NREGS);
    for (int i = 0; i < NREGS; i++) begin
      recv(rb, i == NREGS - 1);
      chk("R5 block read data", rb, exp_reg[i]);
    end
    bus_stop(); #(4*Q);
    chk("R5 released after nack", sda_oe, 0);
    chk("R8 read data stable while SCL high", hi_glitch, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin bank[i] = 8'h00; exp_reg[i] = 8'h00; end
  end

  initial begin
    #950000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule